// File: doc/BRIEF.md
# Sliding-Window Register File

This block is a large general-purpose register store that instructions reach through a small movable window. The store has 4096 entries of 32 bits. An instruction names only logical registers 0 to 31. The block adds each logical number to a window base register to form the physical entry index, and every read and write passes through that base automatically.

A procedure call slides the window up by 16 entries and a procedure return slides it back down by 16. The caller's upper sixteen registers therefore become the callee's lower sixteen. Arguments and results pass between the two through shared storage without any copying.

The block has two combinational read ports and one synchronous write port. Saving windows to memory is not part of this block. A call that would run past the top of the store, or a return below entry zero, is refused and raises a sticky flag.

Top module: `windowed_regfile`

## Requirements
- R1: When the synchronous active-low reset is sampled low at a clock edge, the window base becomes 0 and both the overflow and underflow flags clear.
- R2: Each of the two read ports returns, combinationally, the entry at physical index base + logical number. The sum uses 12-bit arithmetic. The two ports are independent, so different logical numbers give different entries in the same cycle.
- R3: A write with the enable high stores the data at physical index base + logical number at the rising clock edge. Before that edge, a read of the same register still returns the old value.
- R4: A call pulse alone, while base is 4048 or lower, raises base by 16 on the next edge. From reset, 254 calls reach base 4064.
- R5: After a call, logical registers 0 to 15 read the same storage that logical registers 16 to 31 held before the call.
- R6: A return pulse alone, while base is 16 or higher, lowers base by 16 on the next edge.
- R7: A call pulse alone while base is above 4048 leaves base unchanged and sets the overflow flag. The flag stays set until reset.
- R8: A return pulse alone while base is below 16 leaves base unchanged and sets the underflow flag. The flag stays set until reset.
- R9: A write and a call in the same cycle store the data using the base from before the call. The new base applies from the next cycle.
- R10: Call and return pulses in the same cycle leave base unchanged and set neither flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| call_i | input | 1 | Procedure-call pulse: slide window up |
| ret_i | input | 1 | Procedure-return pulse: slide window down |
| rd_a_reg_i | input | 5 | Logical register number, read port A |
| rd_a_data_o | output | 32 | Read data, port A |
| rd_b_reg_i | input | 5 | Logical register number, read port B |
| rd_b_data_o | output | 32 | Read data, port B |
| wr_en_i | input | 1 | Write enable |
| wr_reg_i | input | 5 | Logical register number for the write |
| wr_data_i | input | 32 | Write data |
| win_base_o | output | 12 | Current window base (physical index of logical 0) |
| ovf_o | output | 1 | Sticky flag: a call was refused |
| unf_o | output | 1 | Sticky flag: a return was refused |

## Verification
The assertions check the window controller on every clock edge. They check the exact step size on an accepted call or return, and that a refused move freezes the base and raises the matching flag. They also check that the flags stay set and that the base never leaves the legal range. At the storage they check that each write lands at its physical index. Only the bench scenarios can show the end-to-end effects. These are that data written through one window appears at the shifted logical number after a call or return, that a write coinciding with a call uses the old base, and that the top entry is reachable after a full climb to the last legal base.

// File: rtl/wrf_pkg.sv
// Package: shared defaults and the window-move action type.
// Assumes: window step is half the window size.
package wrf_pkg;
    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_DEPTH  = 4096;
    localparam int unsigned DEF_WIN    = 32;
    localparam int unsigned DEF_STEP   = 16;

    typedef enum logic [2:0] {
        WA_HOLD = 3'd0,
        WA_UP   = 3'd1,
        WA_DOWN = 3'd2,
        WA_OVF  = 3'd3,
        WA_UNF  = 3'd4
    } win_act_e;
endpackage

// File: rtl/wrf_win_decide.sv
// Module: chooses what the window base does this cycle.
// Assumes: base is always a multiple of STEP and at most DEPTH-WIN.
module wrf_win_decide
    import wrf_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    parameter int unsigned WIN   = DEF_WIN,
    parameter int unsigned STEP  = DEF_STEP,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          call_i,
    input  logic          ret_i,
    input  logic [AW-1:0] base_i,
    output win_act_e      act_o
);
    localparam logic [AW-1:0] CALL_LIMIT = AW'(DEPTH - WIN - STEP);
    localparam logic [AW-1:0] STEP_V     = AW'(STEP);

    // Purpose: map the pulses and the current base onto one action.
    always_comb begin
        act_o = WA_HOLD;
        if (call_i && !ret_i) begin
            act_o = (base_i <= CALL_LIMIT) ? WA_UP : WA_OVF;
        end else if (ret_i && !call_i) begin
            act_o = (base_i >= STEP_V) ? WA_DOWN : WA_UNF;
        end
    end
endmodule

// File: rtl/wrf_base_reg.sv
// Module: holds the window base and the sticky overflow/underflow flags.
// Assumes: act_i comes from wrf_win_decide for the same base.
module wrf_base_reg
    import wrf_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    parameter int unsigned WIN   = DEF_WIN,
    parameter int unsigned STEP  = DEF_STEP,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_i,
    input  logic          ret_i,
    input  win_act_e      act_i,
    output logic [AW-1:0] base_o,
    output logic          ovf_o,
    output logic          unf_o
);
    localparam logic [AW-1:0] STEP_V     = AW'(STEP);
    localparam logic [AW-1:0] MAX_BASE   = AW'(DEPTH - WIN);
    localparam logic [AW-1:0] CALL_LIMIT = AW'(DEPTH - WIN - STEP);

    logic [AW-1:0] base_q;
    logic          ovf_q;
    logic          unf_q;

    // Purpose: apply the chosen action to base and flags, synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            case (act_i)
                WA_UP:   base_q <= base_q + STEP_V;
                WA_DOWN: base_q <= base_q - STEP_V;
                WA_OVF:  ovf_q  <= 1'b1;
                WA_UNF:  unf_q  <= 1'b1;
                default: base_q <= base_q;
            endcase
        end
    end

    assign base_o = base_q;
    assign ovf_o  = ovf_q;
    assign unf_o  = unf_q;

    // R4: accepted call moves up by exactly one step
    a_r4_call_step: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && base_q <= CALL_LIMIT) |=> (base_q == $past(base_q) + STEP_V));
    // R6: accepted return moves down by exactly one step
    a_r6_ret_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && base_q >= STEP_V) |=> (base_q == $past(base_q) - STEP_V));
    // R7: refused call freezes base and flags overflow
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && base_q > CALL_LIMIT) |=> ($stable(base_q) && ovf_q));
    // R8: refused return freezes base and flags underflow
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && base_q < STEP_V) |=> ($stable(base_q) && unf_q));
    // R7, R8: flags are sticky
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
    a_r8_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        unf_q |=> unf_q);
    // R10: simultaneous pulses cancel
    a_r10_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i) |=> ($stable(base_q) && ovf_q == $past(ovf_q) && unf_q == $past(unf_q)));
    // R2: window never leaves the store
    a_r2_window_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        base_q <= MAX_BASE);
endmodule

// File: rtl/wrf_index_map.sv
// Module: turns logical register numbers into physical indices.
// Assumes: base + WIN - 1 fits in the store, so no wrap occurs.
module wrf_index_map #(
    parameter int unsigned NPORT = 3,
    parameter int unsigned AW    = 12,
    parameter int unsigned LW    = 5
) (
    input  logic [AW-1:0]            base_i,
    input  logic [NPORT-1:0][LW-1:0] lreg_i,
    output logic [NPORT-1:0][AW-1:0] pidx_o
);
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // Purpose: one adder per port, modulo 2^AW.
        always_comb begin
            pidx_o[p] = base_i + {{(AW-LW){1'b0}}, lreg_i[p]};
        end
    end
endmodule

// File: rtl/wrf_storage.sv
// Module: the physical entry array, combinational reads, one synchronous write.
// Assumes: entries are not reset; software writes before reading.
module wrf_storage #(
    parameter int unsigned DEPTH  = 4096,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NRD    = 2,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [AW-1:0]             wr_idx_i,
    input  logic [DATA_W-1:0]         wr_data_i,
    input  logic [NRD-1:0][AW-1:0]    rd_idx_i,
    output logic [NRD-1:0][DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Purpose: commit a write at the rising edge.
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_idx_i] <= wr_data_i;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        // Purpose: asynchronous read of one port.
        always_comb begin
            rd_data_o[r] = mem_q[rd_idx_i[r]];
        end
    end

    // R3: a write lands at the index presented with it
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (mem_q[$past(wr_idx_i)] == $past(wr_data_i)));
endmodule

// File: rtl/windowed_regfile.sv
// Module: top of the sliding-window register file.
// Assumes: call/return are single-cycle pulses; reset is synchronous, active low.
module windowed_regfile
    import wrf_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned DEPTH  = DEF_DEPTH,
    parameter int unsigned WIN    = DEF_WIN,
    parameter int unsigned STEP   = DEF_STEP,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned LW    = $clog2(WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic [LW-1:0]     rd_a_reg_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [LW-1:0]     rd_b_reg_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [LW-1:0]     wr_reg_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [AW-1:0]     win_base_o,
    output logic              ovf_o,
    output logic              unf_o
);
    localparam int unsigned NMAP = 3;

    win_act_e                    act;
    logic [AW-1:0]               base;
    logic [NMAP-1:0][LW-1:0]     lreg;
    logic [NMAP-1:0][AW-1:0]     pidx;
    logic [1:0][AW-1:0]          rd_idx;
    logic [1:0][DATA_W-1:0]      rd_data;

    wrf_win_decide #(.DEPTH(DEPTH), .WIN(WIN), .STEP(STEP)) u_decide (
        .call_i (call_i),
        .ret_i  (ret_i),
        .base_i (base),
        .act_o  (act)
    );

    wrf_base_reg #(.DEPTH(DEPTH), .WIN(WIN), .STEP(STEP)) u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .call_i (call_i),
        .ret_i  (ret_i),
        .act_i  (act),
        .base_o (base),
        .ovf_o  (ovf_o),
        .unf_o  (unf_o)
    );

    // Purpose: gather the three logical numbers for the index adders.
    always_comb begin
        lreg[0] = rd_a_reg_i;
        lreg[1] = rd_b_reg_i;
        lreg[2] = wr_reg_i;
    end

    wrf_index_map #(.NPORT(NMAP), .AW(AW), .LW(LW)) u_map (
        .base_i (base),
        .lreg_i (lreg),
        .pidx_o (pidx)
    );

    // Purpose: split the mapped indices to the read side.
    always_comb begin
        rd_idx[0] = pidx[0];
        rd_idx[1] = pidx[1];
    end

    wrf_storage #(.DEPTH(DEPTH), .DATA_W(DATA_W), .NRD(2)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_idx_i  (pidx[2]),
        .wr_data_i (wr_data_i),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data)
    );

    assign rd_a_data_o = rd_data[0];
    assign rd_b_data_o = rd_data[1];
    assign win_base_o  = base;

    // R9: a write in a call cycle uses the pre-call base; base moves next cycle
    a_r9_write_old_base: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && call_i && !ret_i && !ovf_o && base <= AW'(DEPTH - WIN - STEP))
        |=> (u_store.mem_q[$past(base) + {{(AW-LW){1'b0}}, $past(wr_reg_i)}] == $past(wr_data_i)));
endmodule

// File: tb/windowed_regfile_tb_top.sv
module windowed_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 1'b0, ret_i = 1'b0, wr_en_i = 1'b0;
    logic [4:0]  rd_a_reg_i = '0, rd_b_reg_i = '0, wr_reg_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rd_a_data_o, rd_b_data_o;
    logic [11:0] win_base_o;
    logic        ovf_o, unf_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    windowed_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
        .rd_a_reg_i(rd_a_reg_i), .rd_a_data_o(rd_a_data_o),
        .rd_b_reg_i(rd_b_reg_i), .rd_b_data_o(rd_b_data_o),
        .wr_en_i(wr_en_i), .wr_reg_i(wr_reg_i), .wr_data_i(wr_data_i),
        .win_base_o(win_base_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    // kind: 0 write, 1 call, 2 return, 3 read-check ; then lreg, data, expected base
    localparam int NV = 13;
    localparam logic [50:0] VEC [NV] = '{
        {2'd0, 5'd20, 32'hA1A1_0001, 12'd0},
        {2'd3, 5'd20, 32'hA1A1_0001, 12'd0},
        {2'd1, 5'd0,  32'h0,         12'd16},
        {2'd3, 5'd4,  32'hA1A1_0001, 12'd16},
        {2'd0, 5'd3,  32'hB2B2_0002, 12'd16},
        {2'd0, 5'd31, 32'hC3C3_0003, 12'd16},
        {2'd2, 5'd0,  32'h0,         12'd0},
        {2'd3, 5'd19, 32'hB2B2_0002, 12'd0},
        {2'd1, 5'd0,  32'h0,         12'd16},
        {2'd1, 5'd0,  32'h0,         12'd32},
        {2'd3, 5'd15, 32'hC3C3_0003, 12'd32},
        {2'd2, 5'd0,  32'h0,         12'd16},
        {2'd2, 5'd0,  32'h0,         12'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, pass one rising edge, return at next negedge
    task automatic step(input logic c, input logic r, input logic we,
                        input logic [4:0] wl, input logic [31:0] wd);
        call_i = c; ret_i = r; wr_en_i = we; wr_reg_i = wl; wr_data_i = wd;
        @(negedge clk);
        call_i = 0; ret_i = 0; wr_en_i = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1 base", {20'd0, win_base_o}, 32'd0);
        check("R1 ovf", {31'd0, ovf_o}, 32'd0);
        check("R1 unf", {31'd0, unf_o}, 32'd0);

        // table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  k;
            logic [4:0]  l;
            logic [31:0] d;
            logic [11:0] b;
            {k, l, d, b} = VEC[i];
            case (k)
                2'd0: step(0, 0, 1, l, d);
                2'd1: step(1, 0, 0, 0, 0);
                2'd2: step(0, 1, 0, 0, 0);
                default: begin
                    rd_a_reg_i = l; #1;
                    check("R5 R2 table read", rd_a_data_o, d);
                end
            endcase
            check("R4 R6 table base", {20'd0, win_base_o}, {20'd0, b});
        end

        // R2: two independent read ports
        step(0, 0, 1, 5'd5, 32'h5555_0005);
        step(0, 0, 1, 5'd6, 32'h6666_0006);
        rd_a_reg_i = 5'd5; rd_b_reg_i = 5'd6; #1;
        check("R2 port A", rd_a_data_o, 32'h5555_0005);
        check("R2 port B", rd_b_data_o, 32'h6666_0006);

        // R3: write not visible before the edge
        step(0, 0, 1, 5'd7, 32'h0000_0071);
        call_i = 0; wr_en_i = 1; wr_reg_i = 5'd7; wr_data_i = 32'h0000_0072;
        rd_a_reg_i = 5'd7; #1;
        check("R3 before edge", rd_a_data_o, 32'h0000_0071);
        @(negedge clk); wr_en_i = 0; #1;
        check("R3 after edge", rd_a_data_o, 32'h0000_0072);

        // R8: return at base 0 refused
        step(0, 1, 0, 0, 0);
        check("R8 base", {20'd0, win_base_o}, 32'd0);
        check("R8 unf", {31'd0, unf_o}, 32'd1);
        step(0, 0, 0, 0, 0);
        check("R8 unf sticky", {31'd0, unf_o}, 32'd1);
        do_reset();
        check("R1 unf cleared", {31'd0, unf_o}, 32'd0);

        // R9: write with call uses old base (phys 17), read as logical 1 after
        step(1, 0, 1, 5'd17, 32'h9999_0009);
        check("R9 base", {20'd0, win_base_o}, 32'd16);
        rd_a_reg_i = 5'd1; #1;
        check("R9 data", rd_a_data_o, 32'h9999_0009);

        // R10: call and return together
        step(1, 1, 0, 0, 0);
        check("R10 base", {20'd0, win_base_o}, 32'd16);
        check("R10 flags", {30'd0, ovf_o, unf_o}, 32'd0);

        // R7: climb to the last legal base, then one more call
        do_reset();
        for (int j = 0; j < 254; j++) step(1, 0, 0, 0, 0);
        check("R4 top base", {20'd0, win_base_o}, 32'd4064);
        check("R7 no ovf yet", {31'd0, ovf_o}, 32'd0);
        step(1, 0, 0, 0, 0);
        check("R7 base frozen", {20'd0, win_base_o}, 32'd4064);
        check("R7 ovf", {31'd0, ovf_o}, 32'd1);
        step(0, 0, 1, 5'd31, 32'hE4E4_0FFF);
        rd_a_reg_i = 5'd31; #1;
        check("R2 top entry", rd_a_data_o, 32'hE4E4_0FFF);
        step(0, 1, 0, 0, 0);
        check("R6 down from top", {20'd0, win_base_o}, 32'd4048);
        check("R7 ovf sticky", {31'd0, ovf_o}, 32'd1);
        do_reset();
        check("R1 ovf cleared", {31'd0, ovf_o}, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule